// File: doc/BRIEF.md
# Accumulator Processor with Index Register

A small 8-bit processor that completes one instruction per clock cycle. Each cycle it reads one instruction byte from an instruction memory port at the program counter. A 4-bit-opcode control decoder turns the upper nibble into a set of control strobes, and the processor then updates the accumulator, the index register, the Zero and Negative flags, the program counter and the data memory port. The lower nibble is the operand. It is a data address or a jump target, and the decoder never looks at it.

Direct instructions reach only data addresses 0x00 to 0x0F, because their operand nibble is zero-extended. The full 8-bit data space, including the I/O window at 0xE0 to 0xFF, is reached only through the index register. The index register is loaded from memory, stepped by one, and used as the address of the indexed load and store. Both memories sit outside the block. Reads are combinational and writes commit on the rising clock edge while the write enable is high. A halt opcode freezes the processor until reset.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and clears the accumulator, the index register, both flags and the halt state. While reset is high the data write enable stays low.
- R2: Opcodes 1, 2, 3 and 4 compute accumulator plus, minus, AND and OR the byte at the direct address. The direct address is the operand nibble zero-extended. The result is written to the accumulator, and subtraction wraps modulo 256.
- R3: Opcode 5 loads the accumulator from the direct address. Opcode 6 drives the direct address, drives the accumulator on write data and raises the write enable, and it leaves the accumulator unchanged. Only opcodes 6 and 11 ever raise the write enable.
- R4: Opcode 7 always loads the program counter with the operand nibble zero-extended. Every instruction that takes no jump and does not halt advances the program counter by one.
- R5: Opcode 8 jumps to the operand target only when the Zero flag is 1, and otherwise falls through.
- R6: Opcode 12 jumps to the operand target only when the Negative flag is 1, and otherwise falls through.
- R7: Opcode 9 loads the index register with the byte at the direct address. Opcode 13 adds one to the index register, wrapping from 0xFF to 0x00, and changes nothing else.
- R8: Opcode 10 loads the accumulator from the address held in the index register. Opcode 11 writes the accumulator to that address. Both ignore the operand nibble and reach the whole 0x00 to 0xFF space, including the window 0xE0 to 0xFF.
- R9: Opcode 15 raises no strobe and freezes the processor. From then on the program counter holds the address of the halt byte, the halted output is 1 and no write occurs until reset.
- R10: Opcode 0 and the unassigned opcode 14 leave the accumulator, the index register, the flags and memory untouched, and only advance the program counter.
- R11: The flags change only when the accumulator is written. Zero becomes 1 when the new value is 0, and Negative copies bit 7 of the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Instruction fetch address (program counter) |
| imem_data | input | 8 | Instruction byte: opcode in bits 7:4, operand in bits 3:0 |
| dmem_addr | output | DATA_W | Data memory address, direct or indexed |
| dmem_wdata | output | DATA_W | Data memory write data (accumulator) |
| dmem_rdata | input | DATA_W | Data memory read data, combinational |
| dmem_we | output | 1 | Data memory write enable |
| halted | output | 1 | Processor is frozen by a halt instruction |

## Verification
The bench builds the block with its defaults, DATA_W = 8 and PC_W = 8. With these values the data address is a full byte, so indexed accesses can target the I/O window at 0xE0 to 0xFF and the index register can wrap from 0xFF to 0x00. Both cases stay out of reach of direct instructions. Short programs fit in the 16 addresses that a jump operand can name. The taken and not-taken branches, the halt freeze and the clearing done by reset are all observed as the stream of data memory writes and the final program counter.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int OPC_W   = 4;
   localparam int INSTR_W = 2 * OPC_W;

   typedef enum logic [OPC_W-1:0] {
      OPC_IDLE   = 4'd0,
      OPC_ADD    = 4'd1,
      OPC_SUB    = 4'd2,
      OPC_AND    = 4'd3,
      OPC_OR     = 4'd4,
      OPC_LOAD   = 4'd5,
      OPC_STORE  = 4'd6,
      OPC_JUMP   = 4'd7,
      OPC_JZERO  = 4'd8,
      OPC_XLOAD  = 4'd9,
      OPC_LOADX  = 4'd10,
      OPC_STOREX = 4'd11,
      OPC_JNEG   = 4'd12,
      OPC_XINC   = 4'd13,
      OPC_SPARE  = 4'd14,
      OPC_HALT   = 4'd15
   } opc_e;

   typedef enum logic [1:0] {
      ALU_ADD = 2'b00,
      ALU_SUB = 2'b01,
      ALU_AND = 2'b10,
      ALU_OR  = 2'b11
   } alu_sel_e;

   typedef struct packed {
      alu_sel_e alu_sel;
      logic     acc_wr;
      logic     acc_from_mem;
      logic     mem_wr;
      logic     jmp_always;
      logic     jmp_zero;
      logic     jmp_neg;
      logic     idx_wr;
      logic     idx_inc;
      logic     idx_addr;
      logic     halt;
   } ctrl_t;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
   import acc_cpu_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   output ctrl_t            ctrl
);

   always_comb begin
      ctrl         = '0;
      ctrl.alu_sel = ALU_ADD;
      case (opc_e'(opcode))
         OPC_ADD: begin
            ctrl.alu_sel = ALU_ADD;
            ctrl.acc_wr  = 1'b1;
         end
         OPC_SUB: begin
            ctrl.alu_sel = ALU_SUB;
            ctrl.acc_wr  = 1'b1;
         end
         OPC_AND: begin
            ctrl.alu_sel = ALU_AND;
            ctrl.acc_wr  = 1'b1;
         end
         OPC_OR: begin
            ctrl.alu_sel = ALU_OR;
            ctrl.acc_wr  = 1'b1;
         end
         OPC_LOAD: begin
            ctrl.acc_wr       = 1'b1;
            ctrl.acc_from_mem = 1'b1;
         end
         OPC_STORE:  ctrl.mem_wr     = 1'b1;
         OPC_JUMP:   ctrl.jmp_always = 1'b1;
         OPC_JZERO:  ctrl.jmp_zero   = 1'b1;
         OPC_JNEG:   ctrl.jmp_neg    = 1'b1;
         OPC_XLOAD:  ctrl.idx_wr     = 1'b1;
         OPC_XINC:   ctrl.idx_inc    = 1'b1;
         OPC_LOADX: begin
            ctrl.acc_wr       = 1'b1;
            ctrl.acc_from_mem = 1'b1;
            ctrl.idx_addr     = 1'b1;
         end
         OPC_STOREX: begin
            ctrl.mem_wr   = 1'b1;
            ctrl.idx_addr = 1'b1;
         end
         OPC_HALT:   ctrl.halt = 1'b1;
         default:    ctrl.halt = 1'b0;
      endcase
   end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_sel_e          sel,
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   output logic [DATA_W-1:0] result
);

   initial begin
      assert (DATA_W >= 2) else $error("acc_cpu_alu: DATA_W must be at least 2");
   end

   always_comb begin
      case (sel)
         ALU_ADD: result = lhs + rhs;
         ALU_SUB: result = lhs - rhs;
         ALU_AND: result = lhs & rhs;
         ALU_OR:  result = lhs | rhs;
         default: result = lhs;
      endcase
   end

endmodule

// File: rtl/acc_cpu_pc.sv
module acc_cpu_pc
   import acc_cpu_pkg::*;
#(
   parameter int PC_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hold,
   input  logic             load,
   input  logic [OPC_W-1:0] target,
   output logic [PC_W-1:0]  pc
);

   logic [PC_W-1:0] target_ext;

   initial begin
      assert (PC_W >= OPC_W) else $error("acc_cpu_pc: PC_W must cover a jump operand");
   end

   generate
      if (PC_W > OPC_W) begin : g_pad
         assign target_ext = {{(PC_W-OPC_W){1'b0}}, target};
      end else begin : g_exact
         assign target_ext = target;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         pc <= '0;
      else if (hold)
         pc <= pc;
      else if (load)
         pc <= target_ext;
      else
         pc <= pc + 1'b1;
   end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PC_W   = 8
) (
   input  logic               clk,
   input  logic               rst,
   output logic [PC_W-1:0]    imem_addr,
   input  logic [7:0]         imem_data,
   output logic [DATA_W-1:0]  dmem_addr,
   output logic [DATA_W-1:0]  dmem_wdata,
   input  logic [DATA_W-1:0]  dmem_rdata,
   output logic               dmem_we,
   output logic               halted
);

   localparam int SIGN_BIT = DATA_W - 1;

   initial begin
      assert (INSTR_W == 8) else $error("acc_cpu: instruction byte must be 8 bits");
      assert (DATA_W >= OPC_W) else $error("acc_cpu: DATA_W must cover a direct operand");
      assert (PC_W >= OPC_W) else $error("acc_cpu: PC_W must cover a jump operand");
   end

   logic [OPC_W-1:0]  opcode;
   logic [OPC_W-1:0]  operand;
   logic [DATA_W-1:0] direct_addr;
   ctrl_t             ctrl_dec;
   ctrl_t             ctrl;
   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] idx_q;
   logic              flag_z;
   logic              flag_n;
   logic              halt_q;
   logic [DATA_W-1:0] alu_y;
   logic [DATA_W-1:0] acc_next;
   logic              take_jump;

   assign opcode  = imem_data[INSTR_W-1:OPC_W];
   assign operand = imem_data[OPC_W-1:0];

   generate
      if (DATA_W > OPC_W) begin : g_addr_pad
         assign direct_addr = {{(DATA_W-OPC_W){1'b0}}, operand};
      end else begin : g_addr_exact
         assign direct_addr = operand;
      end
   endgenerate

   acc_cpu_decode u_decode (
      .opcode (opcode),
      .ctrl   (ctrl_dec)
   );

   assign ctrl = halt_q ? '0 : ctrl_dec;

   acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
      .sel    (ctrl.alu_sel),
      .lhs    (acc_q),
      .rhs    (dmem_rdata),
      .result (alu_y)
   );

   assign take_jump = ctrl.jmp_always
                    | (ctrl.jmp_zero & flag_z)
                    | (ctrl.jmp_neg  & flag_n);

   acc_cpu_pc #(.PC_W(PC_W)) u_pc (
      .clk    (clk),
      .rst    (rst),
      .hold   (ctrl.halt | halt_q),
      .load   (take_jump),
      .target (operand),
      .pc     (imem_addr)
   );

   assign acc_next   = ctrl.acc_from_mem ? dmem_rdata : alu_y;
   assign dmem_addr  = ctrl.idx_addr ? idx_q : direct_addr;
   assign dmem_wdata = acc_q;
   assign dmem_we    = ctrl.mem_wr & ~rst;
   assign halted     = halt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q  <= '0;
         idx_q  <= '0;
         flag_z <= 1'b0;
         flag_n <= 1'b0;
         halt_q <= 1'b0;
      end else begin
         if (ctrl.acc_wr) begin
            acc_q  <= acc_next;
            flag_z <= (acc_next == '0);
            flag_n <= acc_next[SIGN_BIT];
         end
         if (ctrl.idx_wr)
            idx_q <= dmem_rdata;
         else if (ctrl.idx_inc)
            idx_q <= idx_q + 1'b1;
         if (ctrl.halt)
            halt_q <= 1'b1;
      end
   end

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
   parameter int DATA_W = 8,
   parameter int PC_W   = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [PC_W-1:0]   imem_addr,
   input logic [7:0]        imem_data,
   input logic [DATA_W-1:0] dmem_addr,
   input logic              dmem_we,
   input logic              halted
);

   logic [3:0] op;
   logic [3:0] opr;
   logic       no_redirect;

   assign op  = imem_data[7:4];
   assign opr = imem_data[3:0];
   assign no_redirect = (op != 4'd7) && (op != 4'd8) && (op != 4'd12) && (op != 4'd15);

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (imem_addr == '0 && !halted));

   assert_no_write_in_reset_R1: assert property (@(posedge clk)
      rst |-> !dmem_we);

   assert_store_only_R3: assert property (@(posedge clk) disable iff (rst)
      dmem_we |-> (op == 4'd6 || op == 4'd11));

   assert_direct_addr_R3: assert property (@(posedge clk) disable iff (rst)
      (op == 4'd6 && !halted) |-> dmem_addr == DATA_W'(opr));

   assert_pc_step_R4: assert property (@(posedge clk) disable iff (rst)
      (!halted && no_redirect) |=> imem_addr == $past(imem_addr) + 1'b1);

   assert_jump_target_R4: assert property (@(posedge clk) disable iff (rst)
      (!halted && op == 4'd7) |=> imem_addr == PC_W'($past(opr)));

   assert_halt_entry_R9: assert property (@(posedge clk) disable iff (rst)
      (!halted && op == 4'd15) |=> (halted && $stable(imem_addr)));

   assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      halted |=> (halted && $stable(imem_addr)));

   assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      halted |-> !dmem_we);

endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .imem_addr (imem_addr),
   .imem_data (imem_data),
   .dmem_addr (dmem_addr),
   .dmem_we   (dmem_we),
   .halted    (halted)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 8;
   localparam int PC_W       = 8;
   localparam int WATCHDOG   = 20000;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [PC_W-1:0]   imem_addr;
   logic [7:0]        imem_data;
   logic [DATA_W-1:0] dmem_addr;
   logic [DATA_W-1:0] dmem_wdata;
   logic [DATA_W-1:0] dmem_rdata;
   logic              dmem_we;
   logic              halted;

   logic [7:0] imem [256];
   logic [7:0] dmem [256];

   logic [15:0] exp_q [$];
   string       tag_q [$];

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_cpu #(.DATA_W(DATA_W), .PC_W(PC_W)) u_dut (
      .clk        (clk),
      .rst        (rst),
      .imem_addr  (imem_addr),
      .imem_data  (imem_data),
      .dmem_addr  (dmem_addr),
      .dmem_wdata (dmem_wdata),
      .dmem_rdata (dmem_rdata),
      .dmem_we    (dmem_we),
      .halted     (halted)
   );

   assign imem_data  = imem[imem_addr];
   assign dmem_rdata = dmem[dmem_addr];

   always @(posedge clk) begin
      if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
   end

   function automatic logic [7:0] enc(input int op, input int opr);
      return {op[3:0], opr[3:0]};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
      end
   endtask

   task automatic push_exp(input string req, input int addr, input int data);
      exp_q.push_back({addr[7:0], data[7:0]});
      tag_q.push_back(req);
   endtask

   // monitor: pop one expected write per observed strobe
   always @(negedge clk) begin
      if (!rst && dmem_we) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R3", "unexpected write", {dmem_addr, dmem_wdata}, 0);
         end else begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(dmem_addr == e[15:8], t, "write address", dmem_addr, e[15:8]);
            check(dmem_wdata == e[7:0], t, "write data", dmem_wdata, e[7:0]);
         end
      end
   end

   task automatic clear_mems();
      for (int i = 0; i < 256; i++) begin
         imem[i] = 8'h00;
         dmem[i] = 8'h00;
      end
      exp_q.delete();
      tag_q.delete();
   endtask

   task automatic start_reset();
      @(negedge clk);
      rst = 1'b1;
   endtask

   task automatic release_and_run(input string req, input int halt_pc);
      @(negedge clk);
      check(imem_addr == '0, "R1", "pc in reset", imem_addr, 0);
      check(halted == 1'b0, "R1", "halted in reset", halted, 0);
      check(dmem_we == 1'b0, "R1", "write enable in reset", dmem_we, 0);
      rst = 1'b0;
      for (int c = 0; c < 200; c++) begin
         @(negedge clk);
         if (halted) break;
      end
      repeat (3) @(negedge clk);
      check(halted == 1'b1, "R9", "halted at end", halted, 1);
      check(imem_addr == halt_pc[PC_W-1:0], req, "final pc", imem_addr, halt_pc);
      check(exp_q.size() == 0, req, "missing writes", exp_q.size(), 0);
   endtask

   // program A: arithmetic and logic, direct load/store, flags
   task automatic prog_alu();
      start_reset();
      clear_mems();
      dmem[1] = 8'h05; dmem[2] = 8'h03; dmem[3] = 8'h0F; dmem[4] = 8'h30;
      imem[0]  = enc(5, 1);
      imem[1]  = enc(1, 2);
      imem[2]  = enc(6, 8);
      imem[3]  = enc(2, 1);
      imem[4]  = enc(4, 4);
      imem[5]  = enc(6, 9);
      imem[6]  = enc(3, 3);
      imem[7]  = enc(6, 10);
      imem[8]  = enc(2, 1);
      imem[9]  = enc(6, 11);
      imem[10] = enc(12, 13);
      imem[11] = enc(15, 0);
      imem[13] = enc(6, 12);
      imem[14] = enc(15, 0);
      push_exp("R2_add", 8, 8'h08);
      push_exp("R2_or", 9, 8'h33);
      push_exp("R2_and", 10, 8'h03);
      push_exp("R2_sub_wrap", 11, 8'hFE);
      push_exp("R11_neg_flag", 12, 8'hFE);
      release_and_run("R3", 14);
   endtask

   // program B: jumps taken and not taken
   task automatic prog_jumps();
      start_reset();
      clear_mems();
      dmem[1] = 8'h01; dmem[2] = 8'h80;
      imem[0]  = enc(5, 1);
      imem[1]  = enc(8, 4);
      imem[2]  = enc(6, 8);
      imem[3]  = enc(12, 5);
      imem[4]  = enc(2, 1);
      imem[5]  = enc(8, 8);
      imem[6]  = enc(6, 9);
      imem[7]  = enc(15, 0);
      imem[8]  = enc(6, 10);
      imem[9]  = enc(4, 2);
      imem[10] = enc(12, 13);
      imem[11] = enc(6, 11);
      imem[12] = enc(15, 0);
      imem[13] = enc(6, 12);
      imem[14] = enc(7, 7);
      push_exp("R5_not_taken", 8, 8'h01);
      push_exp("R5_taken", 10, 8'h00);
      push_exp("R6_taken", 12, 8'h80);
      release_and_run("R4", 7);
   endtask

   // program C: index register, I/O window, ignored opcodes
   task automatic prog_index();
      start_reset();
      clear_mems();
      dmem[1] = 8'hFE; dmem[8'hFF] = 8'h5A; dmem[3] = 8'hE5; dmem[5] = 8'h5A;
      imem[0]  = enc(9, 1);
      imem[1]  = enc(13, 0);
      imem[2]  = enc(10, 0);
      imem[3]  = enc(13, 0);
      imem[4]  = enc(11, 0);
      imem[5]  = enc(9, 3);
      imem[6]  = enc(11, 7);
      imem[7]  = enc(14, 3);
      imem[8]  = enc(0, 15);
      imem[9]  = enc(6, 4);
      imem[10] = enc(2, 5);
      imem[11] = enc(13, 0);
      imem[12] = enc(8, 14);
      imem[13] = enc(15, 0);
      imem[14] = enc(11, 0);
      imem[15] = enc(15, 0);
      push_exp("R7_inc_wrap", 8'h00, 8'h5A);
      push_exp("R8_io_window", 8'hE5, 8'h5A);
      push_exp("R10_spare_nop", 8'h04, 8'h5A);
      push_exp("R7_inc_keeps_flags", 8'hE6, 8'h00);
      release_and_run("R8", 15);
   endtask

   // program D: halt freezes everything
   task automatic prog_halt();
      start_reset();
      clear_mems();
      dmem[1] = 8'h77;
      imem[0] = enc(5, 1);
      imem[1] = enc(6, 8);
      imem[2] = enc(15, 0);
      imem[3] = enc(6, 9);
      push_exp("R9_before_halt", 8, 8'h77);
      release_and_run("R9", 2);
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         check(imem_addr == 8'd2, "R9", "pc frozen", imem_addr, 2);
         check(halted == 1'b1, "R9", "halt sticky", halted, 1);
      end
   endtask

   // program E: reset clears accumulator, index and flags
   task automatic prog_reset();
      start_reset();
      clear_mems();
      imem[0] = enc(6, 8);
      imem[1] = enc(11, 0);
      imem[2] = enc(8, 4);
      imem[3] = enc(6, 9);
      imem[4] = enc(15, 0);
      dmem[8] = 8'hAA;
      push_exp("R1_acc_cleared", 8, 8'h00);
      push_exp("R1_index_cleared", 0, 8'h00);
      push_exp("R1_zero_flag_cleared", 9, 8'h00);
      release_and_run("R1", 4);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=<%0d", WATCHDOG, WATCHDOG);
      finish_run();
   end

   initial begin
      clear_mems();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      prog_alu();
      prog_jumps();
      prog_index();
      prog_halt();
      prog_reset();
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule